// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Memory Front End

This block sits between an 8051-style host running in expanded multiplexed mode and a small byte-wide memory. The host shares one byte lane between the low address and the data. Five extra pins carry the upper address. An address latch enable strobe marks the address phase. The block recovers the 13-bit address from these pins and demultiplexes the shared lane internally. It then turns the host's chip enable, program-store enable, read and write strobes into program fetches, data reads, writes or standby.

All host pins are asynchronous to the core clock. They pass through a two-flop synchronizer as one bundle, so the address and data stay aligned with the strobes that qualify them. Edges are found in the core clock domain. The top address bit picks one of two planes. Each plane is a behavioural RAM whose stored depth is a parameter. When the parameter is below the full 4K, the offset bits above it fold into the index.

The shared lane is modelled as a data-in bus, a data-out bus and an output enable. The data-out bus reads zero whenever the enable is low. A cycle with both read strobes low is served as a program fetch and raises a protocol error flag.

Top module: `mux_bus_mem`

## Requirements
- R1: While reset is high and on the first clock after it, `bus_oe` and `proto_err` are 0.
- R2: The 13-bit address {`addr_hi`, `bus_in`} is tracked while `ale` is 1 and held once `ale` falls. Later changes on `bus_in` or `addr_hi` while `ale` is 0 do not change the location accessed.
- R3: With `ce_n`=0, `psen_n`=0, `rd_n`=1 and `wr_n`=1 (program fetch), `bus_oe` is 1 and `bus_out` carries the byte at the latched address.
- R4: With `ce_n`=0, `psen_n`=1 and `rd_n`=0 (data read), `bus_oe` is 1 and `bus_out` carries the byte at the latched address.
- R5: With `ce_n`=0, `psen_n`=1 and `rd_n`=1, the last `bus_in` value seen while `wr_n` was 0 is stored at the latched address when `wr_n` rises.
- R6: A `wr_n` rise while `ce_n` is 1 stores nothing, and the previous byte reads back unchanged.
- R7: When `ce_n`=1 and `ale`=0, `standby` is 1 and `bus_oe` is 0 even if a read strobe is low. When `ce_n`=0, `standby` is 0.
- R8: Address bit 12 selects between two independent planes. The same 12-bit offset in each plane holds its own byte.
- R9: `bus_oe` rises on the third rising clock edge after a read strobe falls at the pins. It falls on the third rising edge after the strobe rises. Between those points it stays constant.
- R10: When `ce_n`=0 and both `psen_n` and `rd_n` are 0, the cycle is served as a fetch with `bus_oe`=1 and valid data, and `proto_err` is 1. `proto_err` returns to 0 once either strobe is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address latch enable, high during the address phase |
| ce_n | input | 1 | Chip enable, active low |
| psen_n | input | 1 | Program-store (fetch) read strobe, active low |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; data stored on its rise |
| addr_hi | input | 5 | Upper address bits 12..8 |
| bus_in | input | 8 | Shared lane as seen at the pins: low address or write data |
| bus_out | output | 8 | Read data driven onto the shared lane, zero when not driving |
| bus_oe | output | 1 | Shared lane output enable; 0 means high impedance |
| standby | output | 1 | Chip deselected with latch enable low |
| proto_err | output | 1 | Both read strobes active together |

## Verification
A bad address latch shows at the ports as the wrong byte on `bus_out` at the next read. It shows within the same bus cycle when the bench disturbs the lane after the latch enable falls. A decode that confuses fetch, read or write appears as a missing enable, a spurious enable in standby, or a stored value that reads back wrong. The two-plane vectors catch a swapped plane select in one readback. A synchronizer or enable register that is too deep or too shallow moves the enable edge off the third clock, and the edge-exact latency checks see that at once.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    localparam int LO_W   = 8;
    localparam int HI_W   = 5;
    localparam int ADDR_W = LO_W + HI_W;
    localparam int OFS_W  = ADDR_W - 1;

    // Snapshot of the host pins, carried through the synchronizer as one word
    typedef struct packed {
        logic            ale;
        logic            ce_n;
        logic            psen_n;
        logic            rd_n;
        logic            wr_n;
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } host_pins_t;

    // Fields kept one cycle longer for rising-edge write detection
    typedef struct packed {
        logic            ce_n;
        logic            psen_n;
        logic            rd_n;
        logic            wr_n;
        logic [LO_W-1:0] lo;
    } wr_hist_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FETCH = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } bus_op_e;

    localparam host_pins_t PINS_IDLE = '{ale: 1'b0, ce_n: 1'b1, psen_n: 1'b1,
                                         rd_n: 1'b1, wr_n: 1'b1,
                                         hi: '0, lo: '0};

    // Fetch wins over data read; writes only when neither read strobe is low
    function automatic bus_op_e decode_op(host_pins_t p);
        if (p.ce_n)        return OP_IDLE;
        else if (!p.psen_n) return OP_FETCH;
        else if (!p.rd_n)   return OP_READ;
        else if (!p.wr_n)   return OP_WRITE;
        else                return OP_IDLE;
    endfunction

    function automatic logic is_read(bus_op_e op);
        return (op == OP_FETCH) || (op == OP_READ);
    endfunction

endpackage

// File: rtl/mbm_sync.sv
module mbm_sync
    import mbm_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  host_pins_t pins_raw,
    output host_pins_t pins_sync
);

    host_pins_t chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[s] <= PINS_IDLE;
                else if (s == 0)
                    chain[s] <= pins_raw;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign pins_sync = chain[STAGES-1];

endmodule

// File: rtl/mbm_decode.sv
module mbm_decode
    import mbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  host_pins_t        now,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_fire,
    output logic [LO_W-1:0]   wr_data,
    output logic              rd_en,
    output logic              standby,
    output logic              proto_err
);

    wr_hist_t prev;
    bus_op_e  op_now;

    assign op_now = decode_op(now);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            prev      <= '{ce_n: 1'b1, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, lo: '0};
            rd_en     <= 1'b0;
            standby   <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            if (now.ale)
                addr_q <= {now.hi, now.lo};
            prev      <= '{ce_n: now.ce_n, psen_n: now.psen_n, rd_n: now.rd_n,
                           wr_n: now.wr_n, lo: now.lo};
            rd_en     <= is_read(op_now);
            standby   <= now.ce_n && !now.ale;
            proto_err <= !now.ce_n && !now.psen_n && !now.rd_n;
        end
    end

    // Store on the write strobe's rise, qualified by the pins seen while it was low
    assign wr_fire = !prev.wr_n && now.wr_n && !prev.ce_n && prev.psen_n && prev.rd_n;
    assign wr_data = prev.lo;

    assert_write_needs_ce_R6: assert property (@(posedge clk) disable iff (rst)
        wr_fire |-> $past(!now.ce_n));

    assert_err_served_as_fetch_R10: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> rd_en);

    assert_standby_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        standby |-> !rd_en);

endmodule

// File: rtl/mbm_array.sv
module mbm_array
    import mbm_pkg::*;
#(
    parameter int STORE_W = 9
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [LO_W-1:0]   wdata,
    output logic [LO_W-1:0]   rdata
);

    localparam int DEPTH  = 1 << STORE_W;
    localparam int FOLD_W = OFS_W - STORE_W;

    logic [STORE_W-1:0] idx;
    logic               plane;
    logic               plane_q;
    logic [LO_W-1:0]    plane_q_data [2];

    assign plane = addr[ADDR_W-1];

    generate
        if (FOLD_W > 0) begin : g_fold
            assign idx = addr[STORE_W-1:0] ^ STORE_W'(addr[OFS_W-1:STORE_W]);
        end else begin : g_full
            assign idx = addr[STORE_W-1:0];
        end

        for (genvar p = 0; p < 2; p++) begin : g_plane
            logic [LO_W-1:0] cells [DEPTH];
            always_ff @(posedge clk) begin
                if (we && (plane == 1'(p)))
                    cells[idx] <= wdata;
                plane_q_data[p] <= cells[idx];
            end
        end
    endgenerate

    always_ff @(posedge clk)
        plane_q <= plane;

    assign rdata = plane_q_data[plane_q];

endmodule

// File: rtl/mux_bus_mem.sv
module mux_bus_mem
    import mbm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STORE_W     = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ale,
    input  logic            ce_n,
    input  logic            psen_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic [HI_W-1:0] addr_hi,
    input  logic [LO_W-1:0] bus_in,
    output logic [LO_W-1:0] bus_out,
    output logic            bus_oe,
    output logic            standby,
    output logic            proto_err
);

    host_pins_t        pins_raw;
    host_pins_t        pins_s;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_fire;
    logic [LO_W-1:0]   wr_data;
    logic [LO_W-1:0]   rdata;

    assign pins_raw = '{ale: ale, ce_n: ce_n, psen_n: psen_n, rd_n: rd_n,
                        wr_n: wr_n, hi: addr_hi, lo: bus_in};

    mbm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pins_raw  (pins_raw),
        .pins_sync (pins_s)
    );

    mbm_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .now       (pins_s),
        .addr_q    (addr_q),
        .wr_fire   (wr_fire),
        .wr_data   (wr_data),
        .rd_en     (bus_oe),
        .standby   (standby),
        .proto_err (proto_err)
    );

    mbm_array #(.STORE_W(STORE_W)) u_array (
        .clk   (clk),
        .addr  (addr_q),
        .we    (wr_fire),
        .wdata (wr_data),
        .rdata (rdata)
    );

    assign bus_out = bus_oe ? rdata : '0;

    assert_oe_needs_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> $past(!pins_s.ce_n && (!pins_s.psen_n || !pins_s.rd_n)));

    assert_oe_release_R9: assert property (@(posedge clk) disable iff (rst)
        (pins_s.psen_n && pins_s.rd_n) |=> !bus_oe);

    assert_no_write_while_driving_R5: assert property (@(posedge clk) disable iff (rst)
        wr_fire |-> !$past(bus_oe, 2) || !bus_oe);

    assert_addr_held_R2: assert property (@(posedge clk) disable iff (rst)
        (!pins_s.ale && !$past(pins_s.ale)) |=> $stable(addr_q));

endmodule

// File: tb/mux_bus_mem_tb.sv
module mux_bus_mem_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ale = 1'b0;
    logic       ce_n = 1'b1;
    logic       psen_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [4:0] addr_hi = '0;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic       standby;
    logic       proto_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mux_bus_mem dut_i (
        .clk(clk), .rst(rst), .ale(ale), .ce_n(ce_n), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr_hi), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .standby(standby),
        .proto_err(proto_err)
    );

    // {address[12:0], data[7:0]}
    localparam logic [20:0] VEC [8] = '{
        21'h000A5, 21'h0013C, 21'h0FF5A, 21'h100C3,
        21'h1FF0F, 21'h1000F0, 21'h115599, 21'h11FE81
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic latch_addr(input logic [12:0] a);
        ale = 1'b1; bus_in = a[7:0]; addr_hi = a[12:8];
        waitn(4);
        ale = 1'b0; bus_in = ~a[7:0]; addr_hi = ~a[12:8];
        waitn(4);
    endtask

    task automatic write_byte(input logic [12:0] a, input logic [7:0] d, input bit sel);
        latch_addr(a);
        ce_n = ~sel; bus_in = d; wr_n = 1'b0;
        waitn(4);
        wr_n = 1'b1;
        waitn(4);
        ce_n = 1'b1; bus_in = 8'h00;
        waitn(2);
    endtask

    task automatic read_byte(input logic [12:0] a, input bit fetch,
                             output logic [7:0] d, output logic oe);
        latch_addr(a);
        ce_n = 1'b0;
        if (fetch) psen_n = 1'b0; else rd_n = 1'b0;
        waitn(6);
        d = bus_out; oe = bus_oe;
        psen_n = 1'b1; rd_n = 1'b1;
        waitn(4);
        ce_n = 1'b1;
        waitn(2);
    endtask

    initial begin
        logic [7:0] d;
        logic       oe;
        waitn(3);
        // R1: outputs quiet during reset
        chk(bus_oe == 1'b0 && proto_err == 1'b0, "R1 in reset", {bus_oe, proto_err}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_oe == 1'b0 && proto_err == 1'b0, "R1 after reset", {bus_oe, proto_err}, 0);
        waitn(4);
        // R7: idle pins give standby
        chk(standby == 1'b1, "R7 idle standby", standby, 1);

        // R5: write every vector
        for (int i = 0; i < 8; i++)
            write_byte(VEC[i][20:8], VEC[i][7:0], 1'b1);
        // R3 / R4 alternate: read each back; R2: lane scrambled after latch
        for (int i = 0; i < 8; i++) begin
            read_byte(VEC[i][20:8], (i % 2) == 0, d, oe);
            chk(oe == 1'b1, (i % 2) == 0 ? "R3 fetch oe" : "R4 read oe", oe, 1);
            chk(d == VEC[i][7:0], (i % 2) == 0 ? "R3 R5 R2 fetch data" : "R4 R5 R2 read data",
                d, VEC[i][7:0]);
        end

        // R8: same offset, two planes
        write_byte(13'h0055, 8'h11, 1'b1);
        write_byte(13'h1055, 8'h22, 1'b1);
        read_byte(13'h0055, 1'b0, d, oe);
        chk(d == 8'h11, "R8 plane0", d, 8'h11);
        read_byte(13'h1055, 1'b1, d, oe);
        chk(d == 8'h22, "R8 plane1", d, 8'h22);

        // R6: write with chip deselected is dropped
        write_byte(13'h0001, 8'h77, 1'b0);
        read_byte(13'h0001, 1'b0, d, oe);
        chk(d == 8'h3C, "R6 deselected write", d, 8'h3C);

        // R7: read strobe while deselected
        rd_n = 1'b0;
        waitn(6);
        chk(standby == 1'b1 && bus_oe == 1'b0, "R7 deselected read", {standby, bus_oe}, 2);
        rd_n = 1'b1;
        ce_n = 1'b0;
        waitn(5);
        chk(standby == 1'b0, "R7 selected", standby, 0);
        ce_n = 1'b1;
        waitn(4);

        // R9: edge-exact enable latency
        latch_addr(13'h0000);
        ce_n = 1'b0;
        rd_n = 1'b0;
        waitn(2);
        chk(bus_oe == 1'b0, "R9 before rise", bus_oe, 0);
        waitn(1);
        chk(bus_oe == 1'b1, "R9 rise", bus_oe, 1);
        waitn(3);
        rd_n = 1'b1;
        waitn(2);
        chk(bus_oe == 1'b1, "R9 before fall", bus_oe, 1);
        waitn(1);
        chk(bus_oe == 1'b0, "R9 fall", bus_oe, 0);
        ce_n = 1'b1;
        waitn(4);

        // R10: both read strobes low
        latch_addr(13'h0000);
        ce_n = 1'b0; psen_n = 1'b0; rd_n = 1'b0;
        waitn(6);
        chk(proto_err == 1'b1, "R10 flag", proto_err, 1);
        chk(bus_oe == 1'b1 && bus_out == 8'hA5, "R10 data", bus_out, 8'hA5);
        rd_n = 1'b1;
        waitn(5);
        chk(proto_err == 1'b0, "R10 clear", proto_err, 0);
        chk(bus_out == 8'hA5, "R10 fetch continues", bus_out, 8'hA5);
        psen_n = 1'b1;
        waitn(4);
        ce_n = 1'b1;
        waitn(4);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule